// File: doc/BRIEF.md
# Ramp Controller Bring-Up Sequencer

This block is a self-running bus master that configures a clock-ramp controller after reset without help from a processor. It issues single reads and writes on a simple 32-bit register bus. A transfer is offered with a request, address, write flag and write data, and it finishes in the cycle where the target raises ready. The sequencer works through seven fixed configuration groups held in an internal table. Six groups make up the bring-up run and one forms the shutdown run.

Each group runs in three phases. First, a readiness handshake sets a root-enable flag in the command register and waits for the controller's update-pending flag to drop. Next, the group's data words are written. Last, each slot of the group is committed, counting down from the group's base slot number. A commit sets the slot number and then the commit flag in the config-update register as two separate read-modify-writes. The sequencer then waits for the slot's acknowledge bit, clears the register and waits for the acknowledge field to empty. Every wait is bounded by a cycle budget. If a wait runs out, the run stops and a sticky error code names the failed wait.

Top module: `ramp_init_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `err_code` and `bus_req` are all 0.
- R2: Each group opens with a read of the command register (offset 0x00), then a write of that value with bit 1 set, then reads of the command register that repeat until one returns bit 0 clear.
- R3: The data words of a group are then written once each, at consecutive word addresses starting at the group's first address, in ascending order.
- R4: Each slot commit is a read of the config-update register (offset 0x60) followed by a write of that value ORed with the slot number, then a second read followed by a write of that value with bit 8 set. No other transfer comes between a read and its write.
- R5: After the commit flag is written, the config-update register is read until bit 16+slot is set. Then 0 is written to it, and it is read until bits 31:16 are all zero.
- R6: A group with N slots and base slot S commits slots S, S-1, ... S-N+1 in that order.
- R7: A bring-up run (`init_req`) processes these groups in order: base 6 with 3 words at 0x30; base 14 with 8 words at 0x10; base 3 with 1 word at 0x40; then three one-word groups with base 2 writing 0x800, 0xC00 and 0x400 to 0x50. The data words for 0x30..0x38 are 0x0A513C07, 0x0B624D18, 0x0C735E29; for 0x10..0x2C they are 0x2F000001, 0x2E000103, 0x2D000207, 0x2C00030F, 0x2B00041F, 0x2A00053F, 0x2900067F, 0x280007FF; and for 0x40 it is 0x0003C5A1.
- R8: A shutdown run (`dis_req`) is one group with base 2 that writes 0x0 to 0x50. A request is taken only while idle and free of error, and `init_req` wins if both arrive together.
- R9: A wait that has not succeeded after CLK_MHZ*TIMEOUT_US cycles ends the run at its next failing read. `err` then rises and `err_code` holds 1 for the readiness wait, 2 for the acknowledge wait or 3 for the clear wait. Both stay until reset, no further transfers are issued, and requests are ignored.
- R10: `busy` is high from the cycle after a request is taken until the run ends. `done` clears when a run starts and is set when a run completes every group.
- R11: While `bus_req` is high and `bus_ready` low, `bus_addr`, `bus_we` and `bus_wdata` hold their values in the next cycle.
- R12: Requests that arrive while a run is in progress have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start a bring-up run |
| dis_req | input | 1 | Start a shutdown run |
| bus_req | output | 1 | Transfer offered |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte address of the transfer |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Transfer completes this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| err | output | 1 | A wait timed out |
| err_code | output | 2 | Failed wait: 0 none, 1 ready, 2 ack, 3 clear |

## Verification
The assertions assume that the target raises `bus_ready` only while `bus_req` is high, and that the read data is meaningful in the completing cycle. The bench's target model obeys this. It holds ready for one cycle per transfer, inserts zero to two wait cycles chosen by a small shift register, and answers only at the two control offsets. Its pending, acknowledge and clear delays are set before each run and never change during one. Each timeout case is provoked by having the model withhold a single response for good, so only one wait can ever fail.

// File: rtl/ris_pkg.sv
package ris_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CMD_RD,
      ST_CMD_WR,
      ST_CMD_POLL,
      ST_DATA_WR,
      ST_SLOT_RD,
      ST_SLOT_WR,
      ST_FIRE_RD,
      ST_FIRE_WR,
      ST_ACK_POLL,
      ST_CLR_WR,
      ST_CLR_POLL,
      ST_GRP_END
   } st_e;

   typedef enum logic [1:0] {
      FAIL_NONE  = 2'd0,
      FAIL_READY = 2'd1,
      FAIL_ACK   = 2'd2,
      FAIL_CLEAR = 2'd3
   } fail_e;

   typedef struct packed {
      logic [3:0] base_slot;
      logic [3:0] n_words;
      logic [7:0] first_addr;
      logic [3:0] word0;
   } grp_t;

   localparam int          GRP_W     = 3;
   localparam logic [2:0]  GRP_FIRST = 3'd0;
   localparam logic [2:0]  GRP_LAST  = 3'd5;
   localparam logic [2:0]  GRP_OFF   = 3'd6;
   localparam logic [31:0] ROOT_BIT  = 32'h0000_0002;
   localparam logic [31:0] FIRE_BIT  = 32'h0000_0100;

endpackage

// File: rtl/ris_group_rom.sv
module ris_group_rom
   import ris_pkg::*;
(
   input  logic [GRP_W-1:0] grp_i,
   input  logic [3:0]       word_i,
   output grp_t             desc_o,
   output logic [31:0]      word_o
);

   always_comb begin
      unique case (grp_i)
         3'd0:    desc_o = '{base_slot: 4'd6,  n_words: 4'd3, first_addr: 8'h30, word0: 4'd0};
         3'd1:    desc_o = '{base_slot: 4'd14, n_words: 4'd8, first_addr: 8'h10, word0: 4'd3};
         3'd2:    desc_o = '{base_slot: 4'd3,  n_words: 4'd1, first_addr: 8'h40, word0: 4'd11};
         3'd3:    desc_o = '{base_slot: 4'd2,  n_words: 4'd1, first_addr: 8'h50, word0: 4'd12};
         3'd4:    desc_o = '{base_slot: 4'd2,  n_words: 4'd1, first_addr: 8'h50, word0: 4'd13};
         3'd5:    desc_o = '{base_slot: 4'd2,  n_words: 4'd1, first_addr: 8'h50, word0: 4'd14};
         default: desc_o = '{base_slot: 4'd2,  n_words: 4'd1, first_addr: 8'h50, word0: 4'd15};
      endcase
   end

   always_comb begin
      unique case (word_i)
         4'd0:    word_o = 32'h0A51_3C07;
         4'd1:    word_o = 32'h0B62_4D18;
         4'd2:    word_o = 32'h0C73_5E29;
         4'd3:    word_o = 32'h2F00_0001;
         4'd4:    word_o = 32'h2E00_0103;
         4'd5:    word_o = 32'h2D00_0207;
         4'd6:    word_o = 32'h2C00_030F;
         4'd7:    word_o = 32'h2B00_041F;
         4'd8:    word_o = 32'h2A00_053F;
         4'd9:    word_o = 32'h2900_067F;
         4'd10:   word_o = 32'h2800_07FF;
         4'd11:   word_o = 32'h0003_C5A1;
         4'd12:   word_o = 32'h0000_0800;
         4'd13:   word_o = 32'h0000_0C00;
         4'd14:   word_o = 32'h0000_0400;
         default: word_o = 32'h0000_0000;
      endcase
   end

endmodule

// File: rtl/ris_poll_timer.sv
module ris_poll_timer #(
   parameter int LIMIT = 62500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   generate
      if (LIMIT < 0) begin : g_bad_limit
         $error("ris_poll_timer: LIMIT must not be negative");
      end

      if (LIMIT == 0) begin : g_unbounded
         logic unused_in;
         assign unused_in = ^{clk, rst_n, run};
         assign expired   = 1'b0;
      end else begin : g_bounded
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] CAP = CW'(LIMIT);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt != CAP) cnt <= cnt + 1'b1;
         end

         assign expired = (cnt == CAP);
      end
   endgenerate

endmodule

// File: rtl/ris_bus_drive.sv
module ris_bus_drive
   import ris_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  st_e               st,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] word_addr,
   input  logic [31:0]       word_val,
   input  logic [31:0]       rd_q,
   input  logic [3:0]        slot,
   output logic              req,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [31:0]       wdata
);

   always_comb begin
      req   = 1'b1;
      we    = 1'b0;
      addr  = cfg_addr;
      wdata = '0;
      unique case (st)
         ST_CMD_RD, ST_CMD_POLL: addr = cmd_addr;
         ST_CMD_WR: begin
            we    = 1'b1;
            addr  = cmd_addr;
            wdata = rd_q | ROOT_BIT;
         end
         ST_DATA_WR: begin
            we    = 1'b1;
            addr  = word_addr;
            wdata = word_val;
         end
         ST_SLOT_RD, ST_FIRE_RD, ST_ACK_POLL, ST_CLR_POLL: ;
         ST_SLOT_WR: begin
            we    = 1'b1;
            wdata = rd_q | {28'd0, slot};
         end
         ST_FIRE_WR: begin
            we    = 1'b1;
            wdata = rd_q | FIRE_BIT;
         end
         ST_CLR_WR: we = 1'b1;
         default: begin
            req  = 1'b0;
            addr = '0;
         end
      endcase
   end

endmodule

// File: rtl/ramp_init_seq.sv
module ramp_init_seq
   import ris_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                CLK_MHZ    = 125,
   parameter int                TIMEOUT_US = 500,
   parameter logic [ADDR_W-1:0] CMD_ADDR   = '0,
   parameter logic [ADDR_W-1:0] CFG_OFS    = ADDR_W'(12'h060)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic              dis_req,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_rdata,
   input  logic              bus_ready,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [1:0]        err_code
);

   localparam int TO_CYC = CLK_MHZ * TIMEOUT_US;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ramp_init_seq: ADDR_W must be at least 8");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("ramp_init_seq: CLK_MHZ must be positive");
      end
      if (TIMEOUT_US < 0) begin : g_bad_to
         $error("ramp_init_seq: TIMEOUT_US must not be negative");
      end
   endgenerate

   st_e              st;
   logic [GRP_W-1:0] grp, grp_end;
   logic [3:0]       widx, jdx;
   logic [31:0]      rd_q;
   logic             done_q;
   fail_e            fail_q;

   grp_t              gd;
   logic [31:0]       wval;
   logic [3:0]        slot;
   logic [15:0]       ack_mask;
   logic              xfer, in_poll, expired, last_word, last_slot;
   logic [ADDR_W-1:0] word_addr, cfg_addr;

   ris_group_rom u_rom (
      .grp_i  (grp),
      .word_i (gd.word0 + widx),
      .desc_o (gd),
      .word_o (wval)
   );

   ris_poll_timer #(.LIMIT(TO_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_poll),
      .expired (expired)
   );

   assign cfg_addr  = CMD_ADDR + CFG_OFS;
   assign word_addr = CMD_ADDR + ADDR_W'(gd.first_addr) + ADDR_W'({widx, 2'b00});
   assign slot      = gd.base_slot - jdx;
   assign ack_mask  = 16'd1 << slot;
   assign last_word = (widx == gd.n_words - 4'd1);
   assign last_slot = (jdx == gd.n_words - 4'd1);
   assign xfer      = bus_req & bus_ready;
   assign in_poll   = (st == ST_CMD_POLL) || (st == ST_ACK_POLL) || (st == ST_CLR_POLL);

   ris_bus_drive #(.ADDR_W(ADDR_W)) u_drv (
      .st        (st),
      .cmd_addr  (CMD_ADDR),
      .cfg_addr  (cfg_addr),
      .word_addr (word_addr),
      .word_val  (wval),
      .rd_q      (rd_q),
      .slot      (slot),
      .req       (bus_req),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         grp     <= GRP_FIRST;
         grp_end <= GRP_LAST;
         widx    <= '0;
         jdx     <= '0;
         rd_q    <= '0;
         done_q  <= 1'b0;
         fail_q  <= FAIL_NONE;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (fail_q == FAIL_NONE) begin
                  if (init_req) begin
                     grp     <= GRP_FIRST;
                     grp_end <= GRP_LAST;
                     done_q  <= 1'b0;
                     st      <= ST_CMD_RD;
                  end else if (dis_req) begin
                     grp     <= GRP_OFF;
                     grp_end <= GRP_OFF;
                     done_q  <= 1'b0;
                     st      <= ST_CMD_RD;
                  end
               end
            end
            ST_CMD_RD: if (xfer) begin
               rd_q <= bus_rdata;
               st   <= ST_CMD_WR;
            end
            ST_CMD_WR: if (xfer) st <= ST_CMD_POLL;
            ST_CMD_POLL: if (xfer) begin
               if (!bus_rdata[0]) begin
                  widx <= '0;
                  st   <= ST_DATA_WR;
               end else if (expired) begin
                  fail_q <= FAIL_READY;
                  st     <= ST_IDLE;
               end
            end
            ST_DATA_WR: if (xfer) begin
               if (last_word) begin
                  jdx <= '0;
                  st  <= ST_SLOT_RD;
               end else begin
                  widx <= widx + 4'd1;
               end
            end
            ST_SLOT_RD: if (xfer) begin
               rd_q <= bus_rdata;
               st   <= ST_SLOT_WR;
            end
            ST_SLOT_WR: if (xfer) st <= ST_FIRE_RD;
            ST_FIRE_RD: if (xfer) begin
               rd_q <= bus_rdata;
               st   <= ST_FIRE_WR;
            end
            ST_FIRE_WR: if (xfer) st <= ST_ACK_POLL;
            ST_ACK_POLL: if (xfer) begin
               if ((bus_rdata[31:16] & ack_mask) != 16'd0) begin
                  st <= ST_CLR_WR;
               end else if (expired) begin
                  fail_q <= FAIL_ACK;
                  st     <= ST_IDLE;
               end
            end
            ST_CLR_WR: if (xfer) st <= ST_CLR_POLL;
            ST_CLR_POLL: if (xfer) begin
               if (bus_rdata[31:16] == 16'd0) begin
                  if (last_slot) begin
                     st <= ST_GRP_END;
                  end else begin
                     jdx <= jdx + 4'd1;
                     st  <= ST_SLOT_RD;
                  end
               end else if (expired) begin
                  fail_q <= FAIL_CLEAR;
                  st     <= ST_IDLE;
               end
            end
            ST_GRP_END: begin
               if (grp == grp_end) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  grp <= grp + 1'b1;
                  st  <= ST_CMD_RD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign done     = done_q;
   assign err      = (fail_q != FAIL_NONE);
   assign err_code = fail_q;

endmodule

// File: rtl/ris_checks.sv
module ris_checks #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [1:0]        err_code
);

   // R11: an offered transfer is held unchanged until the target accepts it
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=>
         (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   // R9: the failure report is sticky
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (err && $stable(err_code)));

   // R9: after a failure the bus is quiet and no run is active
   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!bus_req && !busy));

   // R10: completion is only reported when idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: transfers are only offered during a run
   a_r10_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);

endmodule

bind ramp_init_seq ris_checks #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .err_code  (err_code)
);

// File: tb/sim_ramp_init_seq.sv
module sim_ramp_init_seq;

   localparam int AW    = 12;
   localparam int LIMIT = 125;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_req = 1'b0;
   logic          dis_req = 1'b0;
   logic          bus_req, bus_we, bus_ready;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata, bus_rdata;
   logic          busy, done, err;
   logic [1:0]    err_code;

   always #4 clk = ~clk;

   ramp_init_seq #(.ADDR_W(AW), .CLK_MHZ(125), .TIMEOUT_US(1)) u0 (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .dis_req(dis_req),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .busy(busy), .done(done), .err(err), .err_code(err_code)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- target model ----------------
   int   cmd_polls = 0, ack_polls = 1, clr_polls = 0;
   bit   hang_cmd = 0, hang_ack = 0, hang_clr = 0;
   logic [31:0] s_cmd;
   logic [15:0] s_cfg, s_ack;
   int   s_pend, s_ackcd, s_clrcd, s_wait;
   logic [7:0] lfsr;
   logic       rdy_q;
   logic [31:0] rdat_q;

   assign bus_ready = rdy_q;
   assign bus_rdata = rdat_q;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0; rdat_q <= '0; s_cmd <= '0; s_cfg <= '0; s_ack <= '0;
         s_pend <= 0; s_ackcd <= 0; s_clrcd <= 0; s_wait <= 1; lfsr <= 8'h5B;
      end else if (rdy_q) begin
         rdy_q  <= 1'b0;
         lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         s_wait <= int'(lfsr) % 3;
         if (bus_we) begin
            if (bus_addr == 12'h000) begin
               s_cmd <= bus_wdata;
               if (bus_wdata[1]) s_pend <= hang_cmd ? (1 << 30) : cmd_polls;
            end else if (bus_addr == 12'h060) begin
               s_cfg <= bus_wdata[15:0];
               if (bus_wdata == 32'd0) begin
                  if (!hang_clr) begin
                     if (clr_polls == 0) s_ack <= '0;
                     else s_clrcd <= clr_polls;
                  end
               end else if (bus_wdata[8] && !hang_ack) begin
                  if (ack_polls == 0) s_ack <= 16'd1 << bus_wdata[3:0];
                  else s_ackcd <= ack_polls;
               end
            end
         end else begin
            if (bus_addr == 12'h000 && s_pend > 0) s_pend <= s_pend - 1;
            if (bus_addr == 12'h060) begin
               if (s_ackcd > 0) begin
                  if (s_ackcd == 1) s_ack <= 16'd1 << s_cfg[3:0];
                  s_ackcd <= s_ackcd - 1;
               end
               if (s_clrcd > 0) begin
                  if (s_clrcd == 1) s_ack <= '0;
                  s_clrcd <= s_clrcd - 1;
               end
            end
         end
      end else if (bus_req) begin
         if (s_wait > 0) s_wait <= s_wait - 1;
         else begin
            rdy_q <= 1'b1;
            if (bus_addr == 12'h000)      rdat_q <= {s_cmd[31:1], s_pend > 0};
            else if (bus_addr == 12'h060) rdat_q <= {s_ack, s_cfg};
            else                          rdat_q <= 32'h0;
         end
      end
   end

   // ---------------- expected transfer list ----------------
   typedef enum int {K_RD, K_RMW, K_WR, K_PCMD, K_PACK, K_PCLR} kind_e;
   typedef struct {
      kind_e       k;
      logic [11:0] a;
      logic [31:0] v;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [31:0] last_rd = '0;
   bit          mon_on = 1'b0;
   logic [31:0] words[16];

   initial begin
      words = '{32'h0A513C07, 32'h0B624D18, 32'h0C735E29,
                32'h2F000001, 32'h2E000103, 32'h2D000207, 32'h2C00030F,
                32'h2B00041F, 32'h2A00053F, 32'h2900067F, 32'h280007FF,
                32'h0003C5A1, 32'h00000800, 32'h00000C00, 32'h00000400,
                32'h00000000};
   end

   task automatic push(input kind_e k, input logic [11:0] a, input logic [31:0] v,
                       input string tag);
      exp_t e;
      e.k = k; e.a = a; e.v = v; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic add_group(input int base, input int n, input int a0, input int w0,
                            input string wtag);
      push(K_RD,   12'h000, 32'h0, "R2");
      push(K_RMW,  12'h000, 32'h2, "R2");
      push(K_PCMD, 12'h000, 32'h0, "R2");
      for (int i = 0; i < n; i++)
         push(K_WR, 12'(a0 + 4 * i), words[w0 + i], wtag);
      for (int j = 0; j < n; j++) begin
         push(K_RD,   12'h060, 32'h0, "R4");
         push(K_RMW,  12'h060, 32'(base - j), "R6");
         push(K_RD,   12'h060, 32'h0, "R4");
         push(K_RMW,  12'h060, 32'h100, "R4");
         push(K_PACK, 12'h060, 32'(base - j), "R5");
         push(K_WR,   12'h060, 32'h0, "R5");
         push(K_PCLR, 12'h060, 32'h0, "R5");
      end
   endtask

   // compare every completed transfer with the head of the list
   always @(negedge clk) begin
      if (rst_n && mon_on && bus_req && bus_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R12", "unexpected transfer at", longint'(bus_addr), 0);
         end else begin
            exp_t e;
            e = q[0];
            unique case (e.k)
               K_RD: begin
                  chk(!bus_we && bus_addr == e.a, e.tag, "read address",
                      longint'({bus_we, bus_addr}), longint'(e.a));
                  last_rd = bus_rdata;
                  void'(q.pop_front());
               end
               K_RMW: begin
                  chk(bus_we && bus_addr == e.a && bus_wdata == (last_rd | e.v), e.tag,
                      "read-modify-write data", longint'(bus_wdata), longint'(last_rd | e.v));
                  void'(q.pop_front());
               end
               K_WR: begin
                  chk(bus_we && bus_addr == e.a && bus_wdata == e.v, e.tag,
                      "write data", longint'(bus_wdata), longint'(e.v));
                  void'(q.pop_front());
               end
               default: begin
                  if (bus_we || bus_addr != e.a) begin
                     chk(1'b0, e.tag, "poll read address",
                         longint'({bus_we, bus_addr}), longint'(e.a));
                     void'(q.pop_front());
                  end else begin
                     bit sat;
                     if (e.k == K_PCMD)      sat = !bus_rdata[0];
                     else if (e.k == K_PACK) sat = bus_rdata[16 + int'(e.v)];
                     else                    sat = (bus_rdata[31:16] == 16'd0);
                     if (sat) begin
                        chk(1'b1, e.tag, "poll", 0, 0);
                        void'(q.pop_front());
                     end
                  end
               end
            endcase
         end
      end
   end

   // ---------------- watchdog ----------------
   bit finished = 1'b0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         chk(1'b0, "R10", "watchdog expired", 0, 1);
         summary();
      end
   end

   // ---------------- helpers ----------------
   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse(input bit is_init);
      @(negedge clk);
      if (is_init) init_req = 1'b1; else dis_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      dis_req  = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 1;
      while (busy && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic run_fail(input int code);
      int cyc;
      do_reset();
      pulse(1'b1);
      wait_idle(cyc);
      chk(err == 1'b1, "R9", "err after stuck wait", longint'(err), 1);
      chk(err_code == 2'(code), "R9", "err_code", longint'(err_code), longint'(code));
      chk(done == 1'b0, "R9", "done after failure", longint'(done), 0);
      if (code == 1)
         chk(cyc >= LIMIT && cyc <= LIMIT + 24, "R9", "cycles to timeout",
             longint'(cyc), longint'(LIMIT));
      pulse(1'b0);
      pulse(1'b1);
      for (int i = 0; i < 6; i++) begin
         chk(!bus_req && !busy, "R9", "request ignored after error",
             longint'({bus_req, busy}), 0);
         @(negedge clk);
      end
      chk(err_code == 2'(code), "R9", "err_code held", longint'(err_code), longint'(code));
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int cyc;
      do_reset();
      // R1: reset state
      chk(!busy && !done && !err && !bus_req && err_code == 2'd0, "R1", "reset outputs",
          longint'({busy, done, err, bus_req, err_code}), 0);

      // bring-up run, R2..R7, R10, R12
      cmd_polls = 2; ack_polls = 2; clr_polls = 1;
      add_group(6, 3, 12'h030, 0, "R7");
      add_group(14, 8, 12'h010, 3, "R3");
      add_group(3, 1, 12'h040, 11, "R7");
      add_group(2, 1, 12'h050, 12, "R7");
      add_group(2, 1, 12'h050, 13, "R7");
      add_group(2, 1, 12'h050, 14, "R7");
      mon_on = 1'b1;
      pulse(1'b1);
      chk(busy == 1'b1, "R10", "busy after start", longint'(busy), 1);
      repeat (3) @(negedge clk);
      pulse(1'b1);   // R12: ignored mid-run
      pulse(1'b0);
      wait_idle(cyc);
      chk(q.size() == 0, "R7", "outstanding bring-up transfers", longint'(q.size()), 0);
      chk(done && !err, "R10", "done after bring-up", longint'({done, err}), 2);

      // shutdown run, R8
      cmd_polls = 0; ack_polls = 1; clr_polls = 0;
      add_group(2, 1, 12'h050, 15, "R8");
      pulse(1'b0);
      chk(done == 1'b0 && busy == 1'b1, "R10", "done cleared at start",
          longint'({done, busy}), 1);
      wait_idle(cyc);
      chk(q.size() == 0, "R8", "outstanding shutdown transfers", longint'(q.size()), 0);
      chk(done && !err, "R8", "done after shutdown", longint'({done, err}), 2);
      mon_on = 1'b0;

      // timeouts, R9
      hang_cmd = 1; run_fail(1); hang_cmd = 0;
      hang_ack = 1; run_fail(2); hang_ack = 0;
      hang_clr = 1; run_fail(3); hang_clr = 0;

      finished = 1'b1;
      summary();
   end

endmodule